// File: doc/BRIEF.md
# Framed Byte-Stream Register Bridge

This block turns a byte-wide stream into accesses on a register bus with an 8-bit address and 32-bit data. Both stream directions use a valid/ready handshake, as a USB FIFO port might offer. Every host command is a fixed eight-byte frame. The frame starts with 0xAA. Next come an opcode byte, a register address and four payload bytes, and the frame closes with 0xFF. One accepted frame leads to exactly one register access.

A write frame drives its payload onto the bus. A read frame fetches a word, and the bridge then streams back an eight-byte reply frame that carries that word. Frames that are malformed or carry an unknown opcode are dropped with no bus activity. The parser keeps itself aligned on the header byte. Only one command is in flight at a time: the byte input stalls until the bus access, and any reply it needs, has finished. Everything runs on one clock.

Top module: `pkt_reg_bridge`

## Requirements
- R1: While hunting for a frame, any byte other than 0xAA is consumed and discarded with no bus access; 0xAA starts a frame.
- R2: A frame with opcode 0xF0 (byte offset 1) causes one bus write to the address at offset 2; payload offsets 3, 4, 5, 6 form data bits 7:0, 15:8, 23:16, 31:24.
- R3: A frame with opcode 0x0F causes one bus read (bus_we low) at the address at offset 2; its payload bytes have no effect.
- R4: After a read completes, tx carries exactly eight bytes: 0xAA, 0x00, 0x00, read bits 7:0, 15:8, 23:16, 31:24, 0xFF. A write produces no tx bytes.
- R5: If the byte at offset 7 is not 0xFF, the frame is dropped with no bus access, and the next byte is treated as a header candidate.
- R6: A frame whose opcode is neither 0xF0 nor 0xFF-free 0x0F value (any opcode other than 0xF0 or 0x0F) consumes all eight bytes and causes no bus access.
- R7: rx_ready is low from the edge that accepts the trailer of a valid frame until the write is acknowledged or the last reply byte is taken, and high otherwise.
- R8: bus_req rises only for a valid frame and stays high, with address, direction and write data held, until bus_ack; bus_ack while bus_req is low has no effect.
- R9: While tx_valid is high and tx_ready low, tx_valid stays high and tx_data holds its value.
- R10: During and right after reset, rx_ready is high while tx_valid and bus_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | rx_data is valid |
| rx_ready | output | 1 | Bridge accepts a byte this cycle |
| tx_data | output | 8 | Outgoing reply byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Sink takes the byte this cycle |
| bus_req | output | 1 | Register access requested |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completes this cycle |

## Verification
A parser byte index that slips by one shows up on the first following frame. The access then carries the wrong address or a byte-rotated word, or it never appears, so the cycle-accurate model flags it at the cycle where bus_req should rise. A busy flag that clears early or late shows as an rx_ready mismatch in that same cycle. A wrong reply counter shows as a wrong byte or a missing or extra tx_valid on the next reply byte. The model checks every port each clock, so no wrong state hides for more than one frame.

// File: rtl/brg_pkg.sv
package brg_pkg;

   // phase of the command parser
   typedef enum logic {
      PH_HUNT = 1'b0,
      PH_BODY = 1'b1
   } rx_phase_t;

   // phase of the reply serializer
   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_phase_t;

   // bytes of a frame outside the payload: header, opcode, address, trailer
   localparam int FRAME_OVERHEAD = 4;
   // offset of the first payload byte
   localparam int PAYLOAD_OFS    = 3;

endpackage

// File: rtl/brg_rx_parser.sv
module brg_rx_parser
   import brg_pkg::*;
#(
   parameter int                BYTE_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [BYTE_W-1:0] HDR_BYTE = 8'hAA,
   parameter logic [BYTE_W-1:0] TRL_BYTE = 8'hFF,
   parameter logic [BYTE_W-1:0] OP_WR    = 8'hF0,
   parameter logic [BYTE_W-1:0] OP_RD    = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_fire,
   output logic              cmd_fire,
   output logic              cmd_rd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata
);

   localparam int NLANE     = DATA_W / BYTE_W;
   localparam int FRAME_LEN = NLANE + FRAME_OVERHEAD;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] OPC_IDX  = IDX_W'(1);
   localparam logic [IDX_W-1:0] ADR_IDX  = IDX_W'(2);

   rx_phase_t         phase_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] opc_q;
   logic [BYTE_W-1:0] adr_q;
   logic              body_fire;
   logic              opc_known;

   assign body_fire = in_fire && (phase_q == PH_BODY);
   assign opc_known = (opc_q == OP_WR) || (opc_q == OP_RD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_HUNT;
         idx_q   <= '0;
      end else if (in_fire) begin
         if (phase_q == PH_HUNT) begin
            if (in_byte == HDR_BYTE) begin
               phase_q <= PH_BODY;
               idx_q   <= OPC_IDX;
            end
         end else if (idx_q == LAST_IDX) begin
            phase_q <= PH_HUNT;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opc_q <= '0;
         adr_q <= '0;
      end else if (body_fire) begin
         if (idx_q == OPC_IDX) opc_q <= in_byte;
         if (idx_q == ADR_IDX) adr_q <= in_byte;
      end
   end

   // one capture register per payload lane, lane 0 is least significant
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (body_fire && idx_q == IDX_W'(PAYLOAD_OFS + g)) begin
            lane_q <= in_byte;
         end
      end
      assign cmd_wdata[g*BYTE_W +: BYTE_W] = lane_q;
   end

   assign cmd_fire = body_fire && (idx_q == LAST_IDX) &&
                     (in_byte == TRL_BYTE) && opc_known;
   assign cmd_rd   = (opc_q == OP_RD);
   assign cmd_addr = adr_q[ADDR_W-1:0];

endmodule

// File: rtl/brg_bus_port.sv
module brg_bus_port #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fire,
   input  logic              cmd_rd,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_word
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (bus_req) begin
         if (bus_ack) bus_req <= 1'b0;
      end else if (cmd_fire) begin
         bus_req   <= 1'b1;
         bus_we    <= !cmd_rd;
         bus_addr  <= cmd_addr;
         bus_wdata <= cmd_rd ? '0 : cmd_wdata;
      end
   end

   assign rd_done = bus_req && bus_ack && !bus_we;
   assign rd_word = bus_rdata;

endmodule

// File: rtl/brg_tx_framer.sv
module brg_tx_framer
   import brg_pkg::*;
#(
   parameter int                BYTE_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [BYTE_W-1:0] HDR_BYTE = 8'hAA,
   parameter logic [BYTE_W-1:0] TRL_BYTE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              active
);

   localparam int NLANE     = DATA_W / BYTE_W;
   localparam int FRAME_LEN = NLANE + FRAME_OVERHEAD;
   localparam int IDX_W     = $clog2(FRAME_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   tx_phase_t         phase_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] word_q;
   logic [BYTE_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= TX_IDLE;
         idx_q   <= '0;
         word_q  <= '0;
      end else if (phase_q == TX_IDLE) begin
         if (load) begin
            phase_q <= TX_SEND;
            idx_q   <= '0;
            word_q  <= load_word;
         end
      end else if (out_ready) begin
         if (idx_q == LAST_IDX) begin
            phase_q <= TX_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // offsets 1 and 2 carry zero filler
   always_comb begin
      sel = '0;
      if (idx_q == '0)       sel = HDR_BYTE;
      if (idx_q == LAST_IDX) sel = TRL_BYTE;
      for (int l = 0; l < NLANE; l++) begin
         if (idx_q == IDX_W'(PAYLOAD_OFS + l)) sel = word_q[l*BYTE_W +: BYTE_W];
      end
   end

   assign active    = (phase_q == TX_SEND);
   assign out_valid = active;
   assign out_byte  = sel;

endmodule

// File: rtl/pkt_reg_bridge.sv
module pkt_reg_bridge #(
   parameter int                BYTE_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [BYTE_W-1:0] HDR_BYTE = 8'hAA,
   parameter logic [BYTE_W-1:0] TRL_BYTE = 8'hFF,
   parameter logic [BYTE_W-1:0] OP_WR    = 8'hF0,
   parameter logic [BYTE_W-1:0] OP_RD    = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack
);

   if (DATA_W % BYTE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W > BYTE_W) begin : g_bad_addr
      $error("address must fit in one frame byte");
   end
   if (OP_WR == OP_RD) begin : g_bad_ops
      $error("read and write opcodes must differ");
   end

   logic              in_fire;
   logic              cmd_fire;
   logic              cmd_rd;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic              rd_done;
   logic [DATA_W-1:0] rd_word;
   logic              tx_active;

   assign rx_ready = !(bus_req || tx_active);
   assign in_fire  = rx_valid && rx_ready;

   brg_rx_parser #(
      .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .HDR_BYTE(HDR_BYTE), .TRL_BYTE(TRL_BYTE), .OP_WR(OP_WR), .OP_RD(OP_RD)
   ) u_parser (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_byte  (rx_data),
      .in_fire  (in_fire),
      .cmd_fire (cmd_fire),
      .cmd_rd   (cmd_rd),
      .cmd_addr (cmd_addr),
      .cmd_wdata(cmd_wdata)
   );

   brg_bus_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_fire (cmd_fire),
      .cmd_rd   (cmd_rd),
      .cmd_addr (cmd_addr),
      .cmd_wdata(cmd_wdata),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_ack  (bus_ack),
      .rd_done  (rd_done),
      .rd_word  (rd_word)
   );

   brg_tx_framer #(
      .BYTE_W(BYTE_W), .DATA_W(DATA_W),
      .HDR_BYTE(HDR_BYTE), .TRL_BYTE(TRL_BYTE)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rd_done),
      .load_word(rd_word),
      .out_byte (tx_data),
      .out_valid(tx_valid),
      .out_ready(tx_ready),
      .active   (tx_active)
   );

endmodule

// File: rtl/brg_chk.sv
module brg_chk #(
   parameter int                BYTE_W   = 8,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [BYTE_W-1:0] HDR_BYTE = 8'hAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_ready,
   input logic [BYTE_W-1:0] tx_data,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack
);

   // R7
   busy_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req || tx_valid) |-> !rx_ready);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                                 $stable(bus_addr) && $stable(bus_wdata)));

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && tx_valid));

   // R4
   reply_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && !bus_we) |=> (tx_valid && tx_data == HDR_BYTE));

   // R4
   write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && bus_we) |=> (!tx_valid && rx_ready));

endmodule

bind pkt_reg_bridge brg_chk #(
   .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_BYTE(HDR_BYTE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_ready (rx_ready),
   .tx_data  (tx_data),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_ack  (bus_ack)
);

// File: tb/tb_pkt_reg_bridge.sv
module tb_pkt_reg_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic        bus_req;
   logic        bus_we;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;

   always #4 clk = ~clk;

   pkt_reg_bridge dut (
      .clk(clk), .rst_n(rst_n),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   int checks = 0;
   int errors = 0;
   int acc_cnt = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_busy = 1'b0;
   int          m_idx = 0;
   logic [7:0]  m_frame [8];
   bit          exp_we [$];
   logic [7:0]  exp_addr [$];
   logic [31:0] exp_wd [$];
   logic [7:0]  exp_tx [$];
   bit          prev_hold = 1'b0;
   logic [7:0]  prev_data = '0;

   always @(negedge clk) begin
      #3;
      if (!rst_n) begin
         m_busy = 1'b0; m_idx = 0; prev_hold = 1'b0;
         exp_we.delete(); exp_addr.delete(); exp_wd.delete(); exp_tx.delete();
      end else begin
         chk(rx_ready == !m_busy, "R7", "rx_ready", {31'd0, rx_ready}, {31'd0, !m_busy});
         chk(bus_req == (exp_bus_n() > 0), "R8", "bus_req", {31'd0, bus_req},
             {31'd0, exp_bus_n() > 0});
         chk(tx_valid == (exp_tx.size() > 0), "R4", "tx_valid", {31'd0, tx_valid},
             {31'd0, exp_tx.size() > 0});
         if (prev_hold)
            chk(tx_data == prev_data, "R9", "tx_data held", {24'd0, tx_data}, {24'd0, prev_data});
         prev_hold = tx_valid && !tx_ready;
         prev_data = tx_data;

         if (bus_req && exp_bus_n() > 0) begin
            chk(bus_addr == exp_addr[0], "R2", "bus_addr", {24'd0, bus_addr}, {24'd0, exp_addr[0]});
            if (exp_we[0]) begin
               chk(bus_we == 1'b1, "R2", "bus_we", {31'd0, bus_we}, 32'd1);
               chk(bus_wdata == exp_wd[0], "R2", "bus_wdata", bus_wdata, exp_wd[0]);
            end else begin
               chk(bus_we == 1'b0, "R3", "bus_we", {31'd0, bus_we}, 32'd0);
            end
            if (bus_ack) begin
               acc_cnt++;
               if (!exp_we[0]) begin
                  exp_tx.push_back(8'hAA); exp_tx.push_back(8'h00); exp_tx.push_back(8'h00);
                  exp_tx.push_back(bus_rdata[7:0]);   exp_tx.push_back(bus_rdata[15:8]);
                  exp_tx.push_back(bus_rdata[23:16]); exp_tx.push_back(bus_rdata[31:24]);
                  exp_tx.push_back(8'hFF);
               end else begin
                  m_busy = 1'b0;
               end
               void'(exp_we.pop_front()); void'(exp_addr.pop_front()); void'(exp_wd.pop_front());
            end
         end

         if (tx_valid && exp_tx.size() > 0) begin
            chk(tx_data == exp_tx[0], "R4", "tx_data", {24'd0, tx_data}, {24'd0, exp_tx[0]});
            if (tx_ready) begin
               void'(exp_tx.pop_front());
               if (exp_tx.size() == 0) m_busy = 1'b0;
            end
         end

         if (rx_valid && rx_ready) begin
            if (m_idx == 0) begin
               if (rx_data == 8'hAA) begin m_frame[0] = rx_data; m_idx = 1; end
            end else begin
               m_frame[m_idx] = rx_data;
               m_idx++;
               if (m_idx == 8) begin
                  m_idx = 0;
                  if (rx_data == 8'hFF && (m_frame[1] == 8'hF0 || m_frame[1] == 8'h0F)) begin
                     exp_we.push_back(m_frame[1] == 8'hF0);
                     exp_addr.push_back(m_frame[2]);
                     exp_wd.push_back({m_frame[6], m_frame[5], m_frame[4], m_frame[3]});
                     m_busy = 1'b1;
                  end
               end
            end
         end
      end
   end

   function automatic int exp_bus_n();
      return exp_we.size();
   endfunction

   // ---------------- bus responder and tx sink ----------------
   int cyc = 0;
   int wait_cnt = 0;
   int resp_n = 0;

   always @(negedge clk) begin
      cyc++;
      tx_ready = (cyc % 4) != 1;
      if (!rst_n) begin
         bus_ack = 1'b0; wait_cnt = 0;
      end else if (bus_req) begin
         if (wait_cnt >= resp_n % 3) begin
            bus_ack   = 1'b1;
            bus_rdata = {bus_addr, ~bus_addr, 16'h5A00 + 16'(resp_n)};
            resp_n++;
         end else begin
            bus_ack   = 1'b0;
            bus_rdata = 32'hDEAD_BEEF;
         end
         wait_cnt++;
      end else begin
         wait_cnt  = 0;
         bus_ack   = (cyc % 7) == 3;  // stray acks while idle
         bus_rdata = 32'hDEAD_BEEF;
      end
   end

   // ---------------- stimulus ----------------
   task automatic send_byte(input logic [7:0] b);
      rx_data  = b;
      rx_valid = 1'b1;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [7:0] op, input logic [7:0] adr,
                           input logic [31:0] w, input logic [7:0] trl);
      send_byte(8'hAA);
      send_byte(op);
      send_byte(adr);
      for (int k = 0; k < 4; k++) send_byte(w[k*8 +: 8]);
      send_byte(trl);
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (!rx_ready || tx_valid || bus_req) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state while in reset
      chk(rx_ready == 1'b1, "R10", "rx_ready in reset", {31'd0, rx_ready}, 32'd1);
      chk(tx_valid == 1'b0, "R10", "tx_valid in reset", {31'd0, tx_valid}, 32'd0);
      chk(bus_req == 1'b0, "R10", "bus_req in reset", {31'd0, bus_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_ready == 1'b1 && !tx_valid && !bus_req, "R10", "state after reset",
          {29'd0, rx_ready, tx_valid, bus_req}, 32'h4);

      // R1: junk before a header, then a write (R2)
      send_byte(8'h12); send_byte(8'hFF); send_byte(8'h00);
      send_pkt(8'hF0, 8'h34, 32'hA1B2C3D4, 8'hFF);
      wait_idle();
      chk(acc_cnt == 1, "R1", "accesses after junk+write", acc_cnt, 1);

      // R3/R4: read with zero payload
      send_pkt(8'h0F, 8'h56, 32'h0, 8'hFF);
      wait_idle();
      chk(acc_cnt == 2, "R4", "accesses after read", acc_cnt, 2);

      // R3: read with non-zero payload, payload ignored
      send_pkt(8'h0F, 8'h9C, 32'h11223344, 8'hFF);
      wait_idle();
      chk(acc_cnt == 3, "R3", "accesses after read with payload", acc_cnt, 3);

      // R5: bad trailer dropped, then a good write
      send_pkt(8'hF0, 8'h10, 32'h04030201, 8'h00);
      wait_idle();
      chk(acc_cnt == 3, "R5", "no access for bad trailer", acc_cnt, 3);
      send_pkt(8'hF0, 8'h77, 32'hCAFEF00D, 8'hFF);
      wait_idle();
      chk(acc_cnt == 4, "R5", "recovery after bad trailer", acc_cnt, 4);

      // R6: unknown opcode, header-like payload, all eight bytes consumed
      send_pkt(8'h55, 8'hAA, 32'hAAAAAAAA, 8'hFF);
      wait_idle();
      chk(acc_cnt == 4, "R6", "no access for unknown opcode", acc_cnt, 4);
      send_pkt(8'hF0, 8'h01, 32'h00000001, 8'hFF);
      wait_idle();
      chk(acc_cnt == 5, "R6", "alignment after unknown opcode", acc_cnt, 5);

      // R7: back-to-back mixed frames with the bridge stalling the input
      for (int n = 0; n < 6; n++) begin
         if (n % 2 == 0) send_pkt(8'hF0, 8'(8'h40 + n), 32'h01010101 * (n + 1), 8'hFF);
         else            send_pkt(8'h0F, 8'(8'hE0 + n), 32'h0, 8'hFF);
      end
      wait_idle();
      chk(acc_cnt == 11, "R7", "accesses after burst", acc_cnt, 11);
      chk(exp_tx.size() == 0 && exp_bus_n() == 0, "R8", "model drained",
          exp_tx.size() + exp_bus_n(), 0);

      finish_run();
   end

endmodule